// File: doc/BRIEF.md
# Polled Single-Byte Output Controller

This block sits on the device side of a register-mapped link and lets a host move one byte to a downstream consumer using nothing but register polling. The host sees four byte-wide registers: a read-only status word, a command word, an outbound data byte and an inbound capture byte. To send a byte, the host waits until the status word shows the controller idle, loads the outbound byte and the command word (with its write flag) in either order, and finally raises the command-ready flag.

The controller reacts to command-ready by raising its busy flag before it decodes anything. A valid write command then puts the stored byte on the device-side output with a valid strobe, holding it until the consumer accepts it. Completion unwinds the flags in a fixed order (error flag cleared, then command-ready dropped, then busy dropped), so a host that polls status alone knows exactly when the transfer has finished. Malformed commands raise a sticky error flag instead of producing output, and they unwind command-ready and busy in the same order.

Top module: `pollctl_top`

## Requirements
- R1: While reset is asserted and after it is released, all four registers read as zero, busy and error are low and the device-side valid strobe is low.
- R2: Address 0 is the status word (bit 0 busy, bit 1 error, bit 2 a copy of command-ready, other bits zero) and ignores host writes; address 1 is the command word (bit 0 command-ready, bit 1 write flag, bits 7:4 opcode, bits 3:2 read as zero); address 2 is the outbound byte; address 3 is the inbound capture byte, read-only.
- R3: Busy reads high in the second cycle after the command write that set command-ready, and the output strobe is still low in that cycle.
- R4: A command with the write flag set and opcode 0 presents the outbound byte on the device output with the valid strobe held until the consumer's ready input is high; exactly one byte is accepted per command.
- R5: While the output is stalled by a low ready input, busy stays high and the output byte and strobe hold steady.
- R6: After a successful transfer the error flag is cleared first, command-ready is cleared one cycle later while busy is still high, and busy is cleared one cycle after that.
- R7: A command with the write flag clear or with any opcode other than 0 produces no output byte, sets the error flag and leaves it set; command-ready is still cleared while busy is high, then busy is cleared.
- R8: Host writes to the command word or to the outbound byte while busy is high leave both registers unchanged.
- R9: When the device-side capture strobe is high, the inbound byte is stored and reads back at address 3 until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | 2 | Register select for host access |
| host_we | input | 1 | Host write enable |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the selected register |
| dev_data | output | 8 | Outbound byte toward the device side |
| dev_valid | output | 1 | Outbound byte valid strobe |
| dev_ready | input | 1 | Device side accepts the outbound byte |
| cap_data | input | 8 | Inbound byte from the device side |
| cap_valid | input | 1 | Inbound byte capture strobe |

## Verification
The hardest situation to reach is a host write arriving while the controller is mid-transfer, because with a ready consumer the busy window lasts only a handful of cycles. The stimulus holds the consumer's ready input low so the controller parks with busy high and the byte on the output, then writes a new outbound byte and a cleared command word into that window, reads both back, and only then releases ready to confirm the original byte is the one delivered. The flag unwind order is watched by polling status every cycle and checking each falling edge of command-ready and busy against the other flags.

// File: rtl/pollctl_pkg.sv
package pollctl_pkg;

  localparam int OPW = 4;

  // register addresses
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_CMD  = 2'd1;
  localparam logic [1:0] A_DOUT = 2'd2;
  localparam logic [1:0] A_DIN  = 2'd3;

  // status bit positions
  localparam int B_BUSY = 0;
  localparam int B_ERR  = 1;
  localparam int B_GO   = 2;

  // command bit positions
  localparam int C_GO     = 0;
  localparam int C_WR     = 1;
  localparam int C_OP_LSB = 4;

  localparam logic [OPW-1:0] OP_PUT = '0;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DECODE,
    S_SEND,
    S_CLR_ERR,
    S_CLR_GO,
    S_CLR_BUSY
  } seq_state_e;

endpackage

// File: rtl/pollctl_regs.sv
module pollctl_regs
  import pollctl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      addr,
  input  logic            we,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic            busy_i,
  input  logic            err_i,
  input  logic            go_clr_i,
  output logic            go_o,
  output logic            wr_o,
  output logic [OPW-1:0]  op_o,
  output logic [DW-1:0]   dout_o,
  input  logic [DW-1:0]   din_data,
  input  logic            din_valid
);

  logic [DW-1:0]  dout_q, dout_n;
  logic [DW-1:0]  din_q,  din_n;
  logic           go_q,   go_n;
  logic           wr_q,   wr_n;
  logic [OPW-1:0] op_q,   op_n;
  logic           host_wr_ok;

  assign host_wr_ok = we && !busy_i;

  always_comb begin
    dout_n = dout_q;
    din_n  = din_q;
    go_n   = go_q;
    wr_n   = wr_q;
    op_n   = op_q;
    if (din_valid) din_n = din_data;
    if (go_clr_i)  go_n  = 1'b0;
    if (host_wr_ok) begin
      case (addr)
        A_CMD: begin
          go_n = wdata[C_GO];
          wr_n = wdata[C_WR];
          op_n = wdata[C_OP_LSB +: OPW];
        end
        A_DOUT:  dout_n = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      din_q  <= '0;
      go_q   <= 1'b0;
      wr_q   <= 1'b0;
      op_q   <= '0;
    end else begin
      dout_q <= dout_n;
      din_q  <= din_n;
      go_q   <= go_n;
      wr_q   <= wr_n;
      op_q   <= op_n;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_STAT: begin
        rdata[B_BUSY] = busy_i;
        rdata[B_ERR]  = err_i;
        rdata[B_GO]   = go_q;
      end
      A_CMD: begin
        rdata[C_GO]              = go_q;
        rdata[C_WR]              = wr_q;
        rdata[C_OP_LSB +: OPW]   = op_q;
      end
      A_DOUT:  rdata = dout_q;
      default: rdata = din_q;
    endcase
  end

  assign go_o   = go_q;
  assign wr_o   = wr_q;
  assign op_o   = op_q;
  assign dout_o = dout_q;

  // R8
  dout_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(dout_q));

  // R8
  cmd_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(wr_q) && $stable(op_q)));

  // R9
  din_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !din_valid |=> $stable(din_q));

endmodule

// File: rtl/pollctl_seq.sv
module pollctl_seq
  import pollctl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go_i,
  input  logic            wr_i,
  input  logic [OPW-1:0]  op_i,
  input  logic [DW-1:0]   dout_i,
  input  logic            dev_ready,
  output logic [DW-1:0]   dev_data_o,
  output logic            dev_valid_o,
  output logic            busy_o,
  output logic            err_o,
  output logic            go_clr_o
);

  seq_state_e state_q, state_n;
  logic       busy_q, busy_n;
  logic       err_q,  err_n;
  logic       cmd_ok;

  assign cmd_ok = wr_i && (op_i == OP_PUT);

  always_comb begin
    state_n = state_q;
    busy_n  = busy_q;
    err_n   = err_q;
    case (state_q)
      S_IDLE: begin
        if (go_i) begin
          busy_n  = 1'b1;
          state_n = S_DECODE;
        end
      end
      S_DECODE: begin
        if (cmd_ok) begin
          state_n = S_SEND;
        end else begin
          err_n   = 1'b1;
          state_n = S_CLR_GO;
        end
      end
      S_SEND: begin
        if (dev_ready) state_n = S_CLR_ERR;
      end
      S_CLR_ERR: begin
        err_n   = 1'b0;
        state_n = S_CLR_GO;
      end
      S_CLR_GO: begin
        state_n = S_CLR_BUSY;
      end
      S_CLR_BUSY: begin
        busy_n  = 1'b0;
        state_n = S_IDLE;
      end
      default: begin
        busy_n  = 1'b0;
        state_n = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      busy_q  <= busy_n;
      err_q   <= err_n;
    end
  end

  assign dev_valid_o = (state_q == S_SEND);
  assign dev_data_o  = dout_i;
  assign go_clr_o    = (state_q == S_CLR_GO);
  assign busy_o      = busy_q;
  assign err_o       = err_q;

  // R3
  busy_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !dev_valid_o);

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_valid_o && !dev_ready) |=> (dev_valid_o && $stable(dev_data_o)));

  // R5
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid_o |-> busy_o);

  // R6
  go_before_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !go_i);

  // R6
  go_fall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(go_i) |-> busy_o);

  // R7
  err_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (!dev_valid_o && busy_o));

endmodule

// File: rtl/pollctl_top.sv
module pollctl_top
  import pollctl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    host_addr,
  input  logic          host_we,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic [DW-1:0] dev_data,
  output logic          dev_valid,
  input  logic          dev_ready,
  input  logic [DW-1:0] cap_data,
  input  logic          cap_valid
);

  logic           rst_meta, rst_sync;
  logic           busy, err, go, wr, go_clr;
  logic [OPW-1:0] op;
  logic [DW-1:0]  dout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  pollctl_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync),
    .addr      (host_addr),
    .we        (host_we),
    .wdata     (host_wdata),
    .rdata     (host_rdata),
    .busy_i    (busy),
    .err_i     (err),
    .go_clr_i  (go_clr),
    .go_o      (go),
    .wr_o      (wr),
    .op_o      (op),
    .dout_o    (dout),
    .din_data  (cap_data),
    .din_valid (cap_valid)
  );

  pollctl_seq #(.DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync),
    .go_i        (go),
    .wr_i        (wr),
    .op_i        (op),
    .dout_i      (dout),
    .dev_ready   (dev_ready),
    .dev_data_o  (dev_data),
    .dev_valid_o (dev_valid),
    .busy_o      (busy),
    .err_o       (err),
    .go_clr_o    (go_clr)
  );

endmodule

// File: tb/pollctl_top_tb.sv
module pollctl_top_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] host_addr;
  logic       host_we;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic [7:0] dev_data;
  logic       dev_valid;
  logic       dev_ready;
  logic [7:0] cap_data;
  logic       cap_valid;

  int n_chk  = 0;
  int n_fail = 0;
  int rx_cnt = 0;
  logic [7:0] rx_byte = '0;
  bit done = 0;

  // vector: {op[3:0], wr, data[7:0], exp_err}
  localparam int NV = 7;
  localparam logic [13:0] VEC [NV] = '{
    {4'h0, 1'b1, 8'hA5, 1'b0},
    {4'h0, 1'b0, 8'h77, 1'b1},
    {4'h0, 1'b1, 8'h3C, 1'b0},
    {4'h5, 1'b1, 8'h11, 1'b1},
    {4'hF, 1'b1, 8'hFF, 1'b1},
    {4'h0, 1'b1, 8'h00, 1'b0},
    {4'h0, 1'b1, 8'hFF, 1'b0}
  };

  always #4 clk = ~clk;

  pollctl_top u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_we    (host_we),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .dev_data   (dev_data),
    .dev_valid  (dev_valid),
    .dev_ready  (dev_ready),
    .cap_data   (cap_data),
    .cap_valid  (cap_valid)
  );

  always @(negedge clk) begin
    #1;
    if (rst_n && dev_valid && dev_ready) begin
      rx_cnt  = rx_cnt + 1;
      rx_byte = dev_data;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr  = a;
    host_wdata = d;
    host_we    = 1'b1;
    @(negedge clk);
    host_we    = 1'b0;
    host_addr  = 2'd0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    #1;
    d = host_rdata;
    host_addr = 2'd0;
  endtask

  // poll status every cycle until busy falls, checking flag order
  task automatic poll_done(input logic exp_err, input string req);
    logic pb, pg, b, e, g;
    pb = 1'b0;
    pg = 1'b1;
    host_addr = 2'd0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      #1;
      b = host_rdata[0];
      e = host_rdata[1];
      g = host_rdata[2];
      if (i == 0) begin
        chk("R3 busy seen", b, 1'b1);
        chk("R3 no output yet", dev_valid, 1'b0);
      end
      if (pg && !g) begin
        chk({req, " busy high at go fall"}, b, 1'b1);
        chk({req, " err at go fall"}, e, exp_err);
      end
      if (pb && !b) begin
        chk({req, " go low before busy fall"}, pg, 1'b0);
        break;
      end
      pb = b;
      pg = g;
    end
  endtask

  initial begin
    logic [7:0] r;
    logic [13:0] v;
    int c0;
    rst_n = 1'b0;
    host_addr = '0; host_we = 1'b0; host_wdata = '0;
    dev_ready = 1'b1; cap_data = '0; cap_valid = 1'b0;

    // R1 reset state
    repeat (3) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      hread(a[1:0], r);
      chk("R1 reg zero in reset", r, 8'h00);
    end
    chk("R1 valid low in reset", dev_valid, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    hread(2'd0, r);
    chk("R1 status zero after release", r, 8'h00);

    // R2 status ignores writes, cmd layout readback
    hwrite(2'd0, 8'hFF);
    hread(2'd0, r);
    chk("R2 status read-only", r, 8'h00);
    hwrite(2'd2, 8'h5E);
    hread(2'd2, r);
    chk("R2 outbound readback", r, 8'h5E);

    // table walk: R4 R6 R7
    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      c0 = rx_cnt;
      hwrite(2'd2, v[8:1]);
      hwrite(2'd1, {v[13:10], 2'b00, v[9], 1'b1});
      poll_done(v[0], v[0] ? "R7" : "R6");
      hread(2'd1, r);
      chk("R6 cmd readback go clear", r, {v[13:10], 2'b00, v[9], 1'b0});
      hread(2'd0, r);
      chk(v[0] ? "R7 err sticky" : "R6 err cleared", r, {7'd0, v[0]} << 1);
      chk(v[0] ? "R7 no byte out" : "R4 one byte out", rx_cnt - c0, v[0] ? 0 : 1);
      if (!v[0]) chk("R4 byte value", rx_byte, v[8:1]);
    end

    // R5 / R8 stall with writes during busy
    c0 = rx_cnt;
    dev_ready = 1'b0;
    hwrite(2'd2, 8'hC3);
    hwrite(2'd1, 8'h03);
    repeat (3) @(negedge clk);
    hwrite(2'd2, 8'hEE);
    hwrite(2'd1, 8'h00);
    hread(2'd2, r);
    chk("R8 outbound unchanged", r, 8'hC3);
    hread(2'd1, r);
    chk("R8 cmd unchanged", r, 8'h03);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      #1;
      chk("R5 busy during stall", host_rdata[0], 1'b1);
      chk("R5 valid held", {dev_valid, dev_data}, {1'b1, 8'hC3});
    end
    chk("R5 nothing accepted during stall", rx_cnt - c0, 0);
    @(negedge clk);
    dev_ready = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      #1;
      if (!host_rdata[0]) break;
    end
    chk("R4 stalled byte delivered", rx_cnt - c0, 1);
    chk("R8 delivered original byte", rx_byte, 8'hC3);

    // R9 capture path
    @(negedge clk);
    cap_data = 8'h5A; cap_valid = 1'b1;
    @(negedge clk);
    cap_valid = 1'b0; cap_data = 8'h99;
    hread(2'd3, r);
    chk("R9 captured byte", r, 8'h5A);
    hwrite(2'd3, 8'h12);
    hread(2'd3, r);
    chk("R9 capture holds, write ignored", r, 8'h5A);

    // R1 reset in the middle of a stalled transfer
    dev_ready = 1'b0;
    hwrite(2'd2, 8'h81);
    hwrite(2'd1, 8'h03);
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 valid low on mid reset", dev_valid, 1'b0);
    for (int a = 0; a < 4; a++) begin
      hread(a[1:0], r);
      chk("R1 reg zero on mid reset", r, 8'h00);
    end
    @(negedge clk);
    rst_n = 1'b1;
    dev_ready = 1'b1;
    repeat (4) @(negedge clk);
    hread(2'd0, r);
    chk("R1 idle after mid reset", r, 8'h00);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule